// File: doc/BRIEF.md
# Pin-Change Interrupt Demultiplexer

This block sits behind the single shared interrupt line of a 22-input switch sensor and turns it into per-pin edge events plus a separate fault event. The sensor keeps no per-pin latched status. The only way to find out which switch moved is to read its switch-state register and compare it with a copy held locally. When the line is raised, or when status flags gathered from any register reply are still pending, the block asks a register port to read the switch state. It then XORs the new state with its cache and filters the result through a per-pin enable mask and per-pin rising/falling selections. It emits one-cycle fire pulses, one bit per pin.

Configuration arrives as single-pin commands. A command either sets a pin's edge type or sets its enable bit. Level-sensitive types are refused. While a configuration lock is held, changes to the enable mask are collected. When the lock is released, the whole mask goes out to the sensor as two register writes. Each evaluation pass ends with a done pulse and a handled indication, so that a host sharing the line can tell whether this sensor raised it.

Top module: `pin_event_demux`

## Requirements
- R1: After reset the switch-state cache, the enable mask and both edge selections are all zero. No port request, fire pulse, fault pulse, done pulse or configuration error is active.
- R2: While idle, a high `irq_line` or any pending status flag starts a pass. The pass reads address 0x3E (`port_we`=0), and the block holds `port_req`, `port_addr` and `port_we` steady until `port_ack`.
- R3: The changed set is the read state XOR the cache. The cache takes the read state on every pass, including bits of masked pins, so a masked pin that moved fires nothing even after it is later enabled.
- R4: A pin fires on a rising change when its bit changed, now reads 1, is enabled and has rising selected.
- R5: A pin fires on a falling change when its bit changed, now reads 0, is enabled and has falling selected.
- R6: A pin with both edges selected fires on either change. A changed pin that is not enabled never fires.
- R7: Edge-type commands (`cfg_op`=0) use `cfg_arg` bit0=rising, bit1=falling, bit2=level-high, bit3=level-low. A command with bit2 or bit3 set, or one aimed at a pin index above 22, pulses `cfg_err` one cycle later and changes nothing. A type command aimed at index 22 (the fault event) is ignored without an error. Enable commands (`cfg_op`=1) set the pin's enable bit from `cfg_arg` bit0.
- R8: `fault_fire` pulses with the pass result when a fault flag arrived with or before that pass's read reply, whatever the pin settings are.
- R9: A flag that arrives after the read reply of a pass causes another read straight after the pass. With no flag pending, the block returns to idle.
- R10: No mask write is issued while `cfg_lock` is high. After the lock is released with enable changes outstanding, the block writes address 0x1C with mask bits 13:0 in data bits 13:0, then writes address 0x1A with mask bits 21:14 in data bits 7:0. All other data bits are zero.
- R11: `pass_done` pulses one cycle after the read reply is taken. `handled` is high with it only if an enabled pin changed, a fault flag or an interrupt flag was collected.
- R12: A read that equals the cache, such as after a pulse shorter than the read latency, fires nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | 1 | Shared interrupt request, active high |
| flag_valid | input | 1 | A register reply carrying status flags is present this cycle |
| flag_int | input | 1 | Interrupt flag from that reply |
| flag_fault | input | 1 | Fault flag from that reply |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_op | input | 1 | 0 = set edge type, 1 = set enable |
| cfg_pin | input | 5 | Target pin index (22 = fault event) |
| cfg_arg | input | 4 | Command argument, see R7 |
| cfg_lock | input | 1 | Configuration lock; the mask is written on release |
| cfg_err | output | 1 | Rejected command, one-cycle pulse |
| port_req | output | 1 | Register access request |
| port_we | output | 1 | 1 = write, 0 = read |
| port_addr | output | 8 | Register address |
| port_wdata | output | 24 | Write data |
| port_ack | input | 1 | Access completed; read data valid |
| port_rdata | input | 22 | Switch state returned by the read |
| pin_fire | output | 22 | Per-pin event pulses |
| fault_fire | output | 1 | Fault event pulse |
| pass_done | output | 1 | Evaluation pass finished |
| handled | output | 1 | The pass found work, valid with `pass_done` |

## Verification
A cache that missed an update shows up on the next pass as a spurious or missing fire bit, one cycle after the read reply. This is why the bench reads the same state twice across a mask change. A wrong edge selection or mask bit shows up on the very pass that exercises that pin. A lost pending flag shows up as `port_req` staying low in the `pass_done` cycle, where a repeat read was due. A stale enable mask appears in the data of the two writes right after the lock is released.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WR_LO,
    S_WR_HI,
    S_READ,
    S_EVAL
  } seq_state_e;

  localparam int ARG_RISE   = 0;
  localparam int ARG_FALL   = 1;
  localparam int ARG_LVL_HI = 2;
  localparam int ARG_LVL_LO = 3;

  localparam logic CFG_OP_TYPE   = 1'b0;
  localparam logic CFG_OP_ENABLE = 1'b1;
endpackage

// File: rtl/pcd_cfg_regs.sv
module pcd_cfg_regs
  import pcd_pkg::*;
#(
  parameter int NUM_PINS = 22,
  parameter int PIN_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_valid,
  input  logic                cfg_op,
  input  logic [PIN_W-1:0]    cfg_pin,
  input  logic [3:0]          cfg_arg,
  input  logic                cfg_lock,
  input  logic                sync_take,
  output logic [NUM_PINS-1:0] en_mask,
  output logic [NUM_PINS-1:0] rise_en,
  output logic [NUM_PINS-1:0] fall_en,
  output logic                cfg_err,
  output logic                sync_pend
);
  localparam logic [PIN_W-1:0] FAULT_IDX = PIN_W'(NUM_PINS);

  logic lock_q, dirty_q;
  logic is_pin, is_fault, level_req, type_wr, en_wr, bad_cfg, release_ev;

  assign is_pin     = cfg_pin < FAULT_IDX;
  assign is_fault   = cfg_pin == FAULT_IDX;
  assign level_req  = cfg_arg[ARG_LVL_HI] | cfg_arg[ARG_LVL_LO];
  assign type_wr    = cfg_valid && (cfg_op == CFG_OP_TYPE) && is_pin && !level_req;
  assign en_wr      = cfg_valid && (cfg_op == CFG_OP_ENABLE) && is_pin;
  assign bad_cfg    = cfg_valid && (cfg_op == CFG_OP_TYPE) && !is_fault && (level_req || !is_pin);
  assign release_ev = lock_q && !cfg_lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_mask   <= '0;
      rise_en   <= '0;
      fall_en   <= '0;
      cfg_err   <= 1'b0;
      lock_q    <= 1'b0;
      dirty_q   <= 1'b0;
      sync_pend <= 1'b0;
    end else begin
      cfg_err <= bad_cfg;
      lock_q  <= cfg_lock;
      if (type_wr) begin
        rise_en[cfg_pin] <= cfg_arg[ARG_RISE];
        fall_en[cfg_pin] <= cfg_arg[ARG_FALL];
      end
      if (en_wr) begin
        en_mask[cfg_pin] <= cfg_arg[0];
        dirty_q          <= 1'b1;
      end
      if (sync_take) sync_pend <= 1'b0;
      if (release_ev && dirty_q) begin
        sync_pend <= 1'b1;
        dirty_q   <= en_wr;
      end
    end
  end

  // R7
  cfg_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_valid));
  // R7
  cfg_level_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_valid && level_req) |-> ($stable(rise_en) && $stable(fall_en)));
endmodule

// File: rtl/pcd_edge_eval.sv
module pcd_edge_eval #(
  parameter int NUM_PINS = 22
) (
  input  logic [NUM_PINS-1:0] new_state,
  input  logic [NUM_PINS-1:0] cache,
  input  logic [NUM_PINS-1:0] en_mask,
  input  logic [NUM_PINS-1:0] rise_en,
  input  logic [NUM_PINS-1:0] fall_en,
  output logic [NUM_PINS-1:0] fired,
  output logic                any_change
);
  function automatic logic [NUM_PINS-1:0] live_changes(
    input logic [NUM_PINS-1:0] now_v, input logic [NUM_PINS-1:0] old_v,
    input logic [NUM_PINS-1:0] mask_v);
    return (now_v ^ old_v) & mask_v;
  endfunction

  function automatic logic [NUM_PINS-1:0] edge_filter(
    input logic [NUM_PINS-1:0] chg_v, input logic [NUM_PINS-1:0] now_v,
    input logic [NUM_PINS-1:0] up_v, input logic [NUM_PINS-1:0] dn_v);
    return (chg_v & now_v & up_v) | (chg_v & ~now_v & dn_v);
  endfunction

  logic [NUM_PINS-1:0] live_chg;

  assign live_chg   = live_changes(new_state, cache, en_mask);
  assign fired      = edge_filter(live_chg, new_state, rise_en, fall_en);
  assign any_change = |live_chg;
endmodule

// File: rtl/pcd_port_seq.sv
module pcd_port_seq
  import pcd_pkg::*;
#(
  parameter int              NUM_PINS   = 22,
  parameter int              LO_BITS    = 14,
  parameter int              ADDR_W     = 8,
  parameter int              DATA_W     = 24,
  parameter logic [ADDR_W-1:0] STATE_ADDR = 8'h3E,
  parameter logic [ADDR_W-1:0] LO_ADDR    = 8'h1C,
  parameter logic [ADDR_W-1:0] HI_ADDR    = 8'h1A
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_line,
  input  logic                flag_valid,
  input  logic                flag_int,
  input  logic                flag_fault,
  input  logic                sync_pend,
  input  logic [NUM_PINS-1:0] en_mask,
  output logic                sync_take,
  output logic                port_req,
  output logic                port_we,
  output logic [ADDR_W-1:0]   port_addr,
  output logic [DATA_W-1:0]   port_wdata,
  input  logic                port_ack,
  input  logic [NUM_PINS-1:0] port_rdata,
  output logic                in_eval,
  output logic [NUM_PINS-1:0] read_state,
  output logic                snap_int,
  output logic                snap_fault
);
  localparam int HI_BITS = NUM_PINS - LO_BITS;

  seq_state_e state_q;
  logic [1:0] pend_q, incoming;

  assign incoming  = flag_valid ? {flag_fault, flag_int} : 2'b00;
  assign in_eval   = state_q == S_EVAL;
  assign sync_take = (state_q == S_IDLE) && sync_pend;

  always_comb begin
    port_req   = 1'b0;
    port_we    = 1'b0;
    port_addr  = STATE_ADDR;
    port_wdata = '0;
    case (state_q)
      S_WR_LO: begin
        port_req   = 1'b1;
        port_we    = 1'b1;
        port_addr  = LO_ADDR;
        port_wdata = {(DATA_W-LO_BITS)'(0), en_mask[LO_BITS-1:0]};
      end
      S_WR_HI: begin
        port_req   = 1'b1;
        port_we    = 1'b1;
        port_addr  = HI_ADDR;
        port_wdata = {(DATA_W-HI_BITS)'(0), en_mask[NUM_PINS-1:LO_BITS]};
      end
      S_READ:  port_req = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      pend_q     <= 2'b00;
      read_state <= '0;
      snap_int   <= 1'b0;
      snap_fault <= 1'b0;
    end else begin
      pend_q <= pend_q | incoming;
      case (state_q)
        S_IDLE: begin
          if (sync_pend)                          state_q <= S_WR_LO;
          else if (irq_line || (pend_q != 2'b00)) state_q <= S_READ;
        end
        S_WR_LO: if (port_ack) state_q <= S_WR_HI;
        S_WR_HI: if (port_ack) state_q <= S_IDLE;
        S_READ: begin
          if (port_ack) begin
            read_state <= port_rdata;
            {snap_fault, snap_int} <= pend_q | incoming;
            pend_q     <= 2'b00;
            state_q    <= S_EVAL;
          end
        end
        S_EVAL:  state_q <= ((pend_q | incoming) != 2'b00) ? S_READ : S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_req && !port_ack) |=> (port_req && $stable(port_addr) && $stable(port_we)));
  // R2
  rd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_req && !port_we) |-> (port_addr == STATE_ADDR));
  // R10
  wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_req && port_we) |-> ((port_addr == LO_ADDR) || (port_addr == HI_ADDR)));
endmodule

// File: rtl/pin_event_demux.sv
module pin_event_demux
  import pcd_pkg::*;
#(
  parameter int NUM_PINS = 22,
  parameter int LO_BITS  = 14,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 24,
  parameter int PIN_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_line,
  input  logic                flag_valid,
  input  logic                flag_int,
  input  logic                flag_fault,
  input  logic                cfg_valid,
  input  logic                cfg_op,
  input  logic [PIN_W-1:0]    cfg_pin,
  input  logic [3:0]          cfg_arg,
  input  logic                cfg_lock,
  output logic                cfg_err,
  output logic                port_req,
  output logic                port_we,
  output logic [ADDR_W-1:0]   port_addr,
  output logic [DATA_W-1:0]   port_wdata,
  input  logic                port_ack,
  input  logic [NUM_PINS-1:0] port_rdata,
  output logic [NUM_PINS-1:0] pin_fire,
  output logic                fault_fire,
  output logic                pass_done,
  output logic                handled
);
  logic [NUM_PINS-1:0] en_mask, rise_en, fall_en, read_state, cache_q, fired;
  logic sync_pend, sync_take, in_eval, snap_int, snap_fault, any_change;

  pcd_cfg_regs #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_cfg (
    .clk, .rst_n, .cfg_valid, .cfg_op, .cfg_pin, .cfg_arg, .cfg_lock,
    .sync_take, .en_mask, .rise_en, .fall_en, .cfg_err, .sync_pend
  );

  pcd_port_seq #(.NUM_PINS(NUM_PINS), .LO_BITS(LO_BITS),
                 .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk, .rst_n, .irq_line, .flag_valid, .flag_int, .flag_fault,
    .sync_pend, .en_mask, .sync_take, .port_req, .port_we, .port_addr,
    .port_wdata, .port_ack, .port_rdata, .in_eval, .read_state,
    .snap_int, .snap_fault
  );

  pcd_edge_eval #(.NUM_PINS(NUM_PINS)) u_eval (
    .new_state(read_state), .cache(cache_q), .en_mask, .rise_en, .fall_en,
    .fired, .any_change
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cache_q    <= '0;
      pin_fire   <= '0;
      fault_fire <= 1'b0;
      pass_done  <= 1'b0;
      handled    <= 1'b0;
    end else begin
      pin_fire   <= '0;
      fault_fire <= 1'b0;
      pass_done  <= 1'b0;
      handled    <= 1'b0;
      if (in_eval) begin
        cache_q    <= read_state;
        pin_fire   <= fired;
        fault_fire <= snap_fault;
        pass_done  <= 1'b1;
        handled    <= any_change | snap_fault | snap_int;
      end
    end
  end

  // R6
  fire_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pin_fire) |-> ((pin_fire & ~$past(en_mask)) == '0));
  // R11
  fire_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|pin_fire) || fault_fire || handled) |-> pass_done);
  // R11
  done_after_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |-> $past(in_eval));
  // R8
  fault_handled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_fire |-> handled);
endmodule

// File: tb/sim_pin_event_demux.sv
module sim_pin_event_demux;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, irq_line, flag_valid, flag_int, flag_fault;
  logic cfg_valid, cfg_op, cfg_lock, port_ack;
  logic [4:0] cfg_pin;
  logic [3:0] cfg_arg;
  logic [21:0] port_rdata, pin_fire;
  logic cfg_err, port_req, port_we, fault_fire, pass_done, handled;
  logic [7:0] port_addr;
  logic [23:0] port_wdata;

  logic [21:0] m_cache, m_mask, m_rise, m_fall;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_event_demux u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_req(string req, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (port_req) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    if (!ok) chk(req, 32'd0, 32'd1);
  endtask

  task automatic do_cfg(logic op, logic [4:0] pin, logic [3:0] arg, string req);
    logic exp_err = 1'b0;
    @(negedge clk);
    cfg_valid = 1'b1; cfg_op = op; cfg_pin = pin; cfg_arg = arg;
    @(negedge clk);
    cfg_valid = 1'b0;
    if (op == 1'b0) begin
      if (pin < 5'd22) begin
        if (arg[3:2] != 2'b00) exp_err = 1'b1;
        else begin m_rise[pin] = arg[0]; m_fall[pin] = arg[1]; end
      end else if (pin != 5'd22) exp_err = 1'b1;
    end else if (pin < 5'd22) m_mask[pin] = arg[0];
    chk({req, " cfg_err"}, {31'd0, cfg_err}, {31'd0, exp_err});
  endtask

  task automatic do_pass(logic [21:0] data, bit fault, bit intf, bit repoll,
                         bit use_irq, string req);
    logic [21:0] m, exp_fire;
    bit ok;
    if (use_irq) begin
      @(negedge clk); irq_line = 1'b1;
      @(negedge clk);
    end
    wait_req({req, " read request"}, ok);
    if (!ok) return;
    chk({req, " R2 read addr"}, {24'd0, port_addr}, 32'h3E);
    chk({req, " R2 read we"}, {31'd0, port_we}, 32'd0);
    port_ack = 1'b1; port_rdata = data; irq_line = 1'b0;
    flag_valid = fault | intf; flag_fault = fault; flag_int = intf;
    @(negedge clk);
    port_ack = 1'b0;
    flag_valid = repoll; flag_int = repoll; flag_fault = 1'b0;
    @(negedge clk);
    flag_valid = 1'b0; flag_int = 1'b0;
    m = (data ^ m_cache) & m_mask;
    exp_fire = (m & data & m_rise) | (m & ~data & m_fall);
    m_cache = data;
    chk({req, " pin_fire"}, {10'd0, pin_fire}, {10'd0, exp_fire});
    chk({req, " R8 fault_fire"}, {31'd0, fault_fire}, {31'd0, fault});
    chk({req, " R11 pass_done"}, {31'd0, pass_done}, 32'd1);
    chk({req, " R11 handled"}, {31'd0, handled}, {31'd0, (|m) | fault | intf});
    chk({req, " R9 reread"}, {31'd0, port_req}, {31'd0, repoll});
  endtask

  task automatic t_reset();
    chk("R1 port_req", {31'd0, port_req}, 32'd0);
    chk("R1 pin_fire", {10'd0, pin_fire}, 32'd0);
    chk("R1 fault_fire", {31'd0, fault_fire}, 32'd0);
    chk("R1 pass_done", {31'd0, pass_done}, 32'd0);
    chk("R1 cfg_err", {31'd0, cfg_err}, 32'd0);
    do_cfg(1'b0, 5'd0, 4'b0001, "R1");
    do_cfg(1'b1, 5'd0, 4'b0001, "R1");
    do_pass(22'h000005, 0, 0, 0, 1, "R1 cache starts zero");
  endtask

  task automatic t_mask_cache();
    do_cfg(1'b0, 5'd2, 4'b0001, "R3");
    do_cfg(1'b1, 5'd2, 4'b0001, "R3");
    do_pass(22'h000005, 0, 0, 0, 1, "R3 masked change absorbed");
  endtask

  task automatic t_rise();
    do_cfg(1'b0, 5'd1, 4'b0001, "R4");
    do_cfg(1'b1, 5'd1, 4'b0001, "R4");
    do_pass(22'h000007, 0, 0, 0, 1, "R4 rising");
  endtask

  task automatic t_fall();
    do_cfg(1'b0, 5'd2, 4'b0010, "R5");
    do_pass(22'h000003, 0, 0, 0, 1, "R5 falling");
  endtask

  task automatic t_both();
    do_cfg(1'b0, 5'd21, 4'b0011, "R6");
    do_cfg(1'b1, 5'd21, 4'b0001, "R6");
    do_cfg(1'b0, 5'd14, 4'b0011, "R6");
    do_cfg(1'b1, 5'd14, 4'b0001, "R6");
    do_pass(22'h304003, 0, 0, 0, 1, "R6 both rise, pin20 masked");
    do_pass(22'h000003, 0, 0, 0, 1, "R6 both fall");
  endtask

  task automatic t_level();
    do_cfg(1'b0, 5'd0, 4'b0101, "R7 level high rejected");
    do_cfg(1'b0, 5'd0, 4'b1010, "R7 level low rejected");
    do_pass(22'h000002, 0, 0, 0, 1, "R7 type kept (no fall)");
    do_pass(22'h000003, 0, 0, 0, 1, "R7 type kept (rise)");
    do_cfg(1'b0, 5'd22, 4'b0100, "R7 fault type ignored");
    do_cfg(1'b0, 5'd25, 4'b0001, "R7 bad index");
  endtask

  task automatic t_fault();
    do_pass(22'h000003, 1, 0, 0, 1, "R8 fault");
    do_pass(22'h000003, 0, 1, 0, 1, "R11 int only");
  endtask

  task automatic t_repoll();
    do_pass(22'h000001, 0, 0, 1, 1, "R9 first pass");
    do_pass(22'h000001, 0, 1, 0, 0, "R9 second pass");
  endtask

  task automatic t_short_pulse();
    do_pass(22'h000001, 0, 0, 0, 1, "R12 equal state");
    chk("R12 no cfg_err", {31'd0, cfg_err}, 32'd0);
  endtask

  task automatic t_sync();
    bit ok;
    @(negedge clk); cfg_lock = 1'b1;
    do_cfg(1'b1, 5'd3, 4'b0001, "R10");
    do_cfg(1'b1, 5'd15, 4'b0001, "R10");
    do_cfg(1'b1, 5'd14, 4'b0000, "R10");
    repeat (3) @(negedge clk);
    chk("R10 no write while locked", {31'd0, port_req}, 32'd0);
    cfg_lock = 1'b0;
    @(negedge clk);
    wait_req("R10 write request", ok);
    if (!ok) return;
    chk("R10 first write we", {31'd0, port_we}, 32'd1);
    chk("R10 first write addr", {24'd0, port_addr}, 32'h1C);
    chk("R10 first write data", {8'd0, port_wdata}, {18'd0, m_mask[13:0]});
    port_ack = 1'b1;
    @(negedge clk); port_ack = 1'b0;
    chk("R10 second write req", {31'd0, port_req}, 32'd1);
    chk("R10 second write addr", {24'd0, port_addr}, 32'h1A);
    chk("R10 second write data", {8'd0, port_wdata}, {24'd0, m_mask[21:14]});
    port_ack = 1'b1;
    @(negedge clk); port_ack = 1'b0;
    @(negedge clk);
    chk("R10 sequence ends", {31'd0, port_req}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; irq_line = 1'b0; flag_valid = 1'b0; flag_int = 1'b0;
    flag_fault = 1'b0; cfg_valid = 1'b0; cfg_op = 1'b0; cfg_pin = '0;
    cfg_arg = '0; cfg_lock = 1'b0; port_ack = 1'b0; port_rdata = '0;
    m_cache = '0; m_mask = '0; m_rise = '0; m_fall = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_cache();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_fault();
    t_repoll();
    t_short_pulse();
    t_sync();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule